// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. A one-cycle start strobe from software begins a conversion frame. The sequencer first waits a short hold-off when the independent RC timebase is selected. It then counts twelve conversion-clock periods. The first period is setup, the next ten each try one bit of the DAC code from the most significant bit down, and the last period latches the code into the result register.

The comparator, the DAC and the sample-and-hold sit outside the block. The sequencer drives the trial code and a sample-enable level, and it reads a single comparator bit that reports whether the held input is at or above the present DAC level. The busy flag doubles as the done indication: it reads high while a frame runs and drops at completion. At the same edge the interrupt flag rises, and the flag stays set until software clears it with a strobe.

All pins are plain levels or single-cycle strobes. No stream interface is involved, so there is no back-pressure: the result register simply holds its value until the next completed frame overwrites it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `go_done`=0, `irq_flag`=0, `result`=0, `dac_code`=0 and `sample_en`=1.
- R2: A `go_wr` pulse while idle starts a frame. From the next cycle `go_done`=1 and `sample_en`=0, and `dac_code` reads 0 during the setup period.
- R3: With `clk_sel`=0 a conversion period lasts D system clocks, where `div_sel` 0 gives D=2, 1 gives D=8, and 2 or 3 give D=32. `go_done` falls exactly 12·D clock edges after the edge that accepted `go_wr`.
- R4: With `clk_sel`=1 the sequencer holds off for 4 system clocks after acceptance and ignores `rc_tick` during that time. It then treats each high `rc_tick` cycle as the end of one period and completes on the 12th counted tick.
- R5: Bits are tried from bit 9 down to bit 0, one per period in periods 1 to 10. A trial bit is set in `dac_code` at the start of its period and kept only if `comp_hi`=1 at the end of that period. With an ideal comparator, the final code is the largest code not above the input.
- R6: `result` keeps its previous value throughout a frame and takes the new code at the completion edge.
- R7: At completion `go_done` falls, `sample_en` rises and `irq_flag` is set in the same edge. `irq_flag` never rises at any other time.
- R8: A `go_wr` pulse during a frame is ignored: the frame neither restarts nor lengthens.
- R9: An `irq_clr` pulse clears `irq_flag`. If it coincides with a completion edge, the flag is set.
- R10: `clk_sel` and `div_sel` are captured when `go_wr` is accepted. Changes later in the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_wr | input | 1 | Start strobe (software write of the busy bit) |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| clk_sel | input | 1 | 0: periods from system clock divider, 1: periods from `rc_tick` |
| div_sel | input | 2 | Divider choice: 0→2, 1→8, 2/3→32 system clocks |
| rc_tick | input | 1 | One-cycle period-end pulse from the RC timebase |
| comp_hi | input | 1 | Comparator: input at or above DAC level |
| dac_code | output | 10 | Trial code for the DAC |
| sample_en | output | 1 | High while the sample-and-hold tracks the input |
| result | output | 10 | Result register |
| go_done | output | 1 | High while converting, low when done |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
A frame accepted at a given edge ends exactly 12·D edges later in divided mode. In RC mode it ends one edge after the twelfth `rc_tick` that arrives after the four-cycle hold-off. The bench counts edges from the accepting edge, sampling at falling edges, and compares that count with 12·D. It also compares `result`, `irq_flag` and `sample_en` on the falling edge just after completion. The coincidence and interference cases (a clear strobe on the completion edge, a restart mid-frame, a divider change after acceptance) are injected at a counted edge offset. Their effects are judged only at the cycle where completion is due.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_HOLDOFF = 2'd1,
    PH_CONVERT = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       use_rc,
  input  logic [1:0] div_sel,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int CW = (DIV_C > 2) ? $clog2(DIV_C) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          wrap;

  // terminal count of the divider for the captured setting
  always_comb begin
    case (div_sel)
      2'd0:    lim = CW'(DIV_A - 1);
      2'd1:    lim = CW'(DIV_B - 1);
      default: lim = CW'(DIV_C - 1);
    endcase
  end

  assign wrap = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || use_rc)  cnt <= '0;
    else if (wrap)            cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick = run & (use_rc ? rc_tick : wrap);
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_seq_pkg::*;
#(
  parameter int FRAME   = 12,
  parameter int HOLDOFF = 4,
  parameter int PW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_wr,
  input  logic          clk_sel,
  input  logic [1:0]    div_sel,
  input  logic          tick,
  output logic          busy,
  output logic          run,
  output logic          use_rc,
  output logic [1:0]    div_q,
  output logic [PW-1:0] pcnt,
  output logic          start,
  output logic          done_evt
);
  localparam int HW = (HOLDOFF > 1) ? $clog2(HOLDOFF) : 1;

  phase_e        phase;
  logic [HW-1:0] hold_cnt;
  logic          last_period;

  assign start       = (phase == PH_IDLE) && go_wr;
  assign run         = (phase == PH_CONVERT);
  assign busy        = (phase != PH_IDLE);
  assign last_period = (pcnt == PW'(FRAME - 1));
  assign done_evt    = run && tick && last_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      hold_cnt <= '0;
      pcnt     <= '0;
      use_rc   <= 1'b0;
      div_q    <= 2'd0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (go_wr) begin
            use_rc   <= clk_sel;
            div_q    <= div_sel;
            pcnt     <= '0;
            hold_cnt <= '0;
            phase    <= clk_sel ? PH_HOLDOFF : PH_CONVERT;
          end
        end
        PH_HOLDOFF: begin
          if (hold_cnt == HW'(HOLDOFF - 1)) phase <= PH_CONVERT;
          else                              hold_cnt <= hold_cnt + 1'b1;
        end
        PH_CONVERT: begin
          if (tick) begin
            if (last_period) phase <= PH_IDLE;
            else             pcnt  <= pcnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int NBITS = 10,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [PW-1:0]    pcnt,
  input  logic             comp_hi,
  output logic [NBITS-1:0] code
);
  // period p ends: resolve bit NBITS-p, then arm bit NBITS-1-p
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (clear) begin
      code <= '0;
    end else if (step) begin
      for (int i = 0; i < NBITS; i++) begin
        if (int'(pcnt) == NBITS - i)          code[i] <= comp_hi;
        else if (int'(pcnt) == NBITS - 1 - i) code[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NBITS   = 10,
  parameter int HOLDOFF = 4,
  parameter int DIV_A   = 2,
  parameter int DIV_B   = 8,
  parameter int DIV_C   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_wr,
  input  logic             irq_clr,
  input  logic             clk_sel,
  input  logic [1:0]       div_sel,
  input  logic             rc_tick,
  input  logic             comp_hi,
  output logic [NBITS-1:0] dac_code,
  output logic             sample_en,
  output logic [NBITS-1:0] result,
  output logic             go_done,
  output logic             irq_flag
);
  localparam int FRAME = NBITS + 2;
  localparam int PW    = $clog2(FRAME);

  logic          busy, run, use_rc, start, done_evt, tick;
  logic [1:0]    div_q;
  logic [PW-1:0] pcnt;

  adc_frame_fsm #(.FRAME(FRAME), .HOLDOFF(HOLDOFF), .PW(PW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .clk_sel(clk_sel),
    .div_sel(div_sel), .tick(tick), .busy(busy), .run(run),
    .use_rc(use_rc), .div_q(div_q), .pcnt(pcnt), .start(start),
    .done_evt(done_evt)
  );

  adc_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .use_rc(use_rc),
    .div_sel(div_q), .rc_tick(rc_tick), .tick(tick)
  );

  adc_sar_reg #(.NBITS(NBITS), .PW(PW)) u_sar (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(tick),
    .pcnt(pcnt), .comp_hi(comp_hi), .code(dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result <= '0;
    else if (done_evt) result <= dac_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (done_evt) irq_flag <= 1'b1;
    else if (irq_clr)  irq_flag <= 1'b0;
  end

  assign go_done   = busy;
  assign sample_en = ~busy;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int NBITS = 10,
  parameter int FRAME = 12,
  parameter int PW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_wr,
  input logic             irq_clr,
  input logic             go_done,
  input logic             irq_flag,
  input logic             sample_en,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-1:0] result,
  input logic             done_evt,
  input logic [PW-1:0]    pcnt
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_done && go_wr) |=> (go_done && !sample_en && dac_code == '0));

  a_r3_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    go_done |-> (int'(pcnt) < FRAME));

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    go_done |=> ($stable(result) || !go_done));

  a_r7_done_effects: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq_flag && !go_done && sample_en));

  a_r7_irq_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !done_evt) |=> !irq_flag);

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (go_done && !done_evt) |=> go_done);

  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !done_evt) |=> !irq_flag);
endmodule

bind adc_seq_ctrl adc_seq_checker #(.NBITS(NBITS), .FRAME(FRAME), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .irq_clr(irq_clr),
  .go_done(go_done), .irq_flag(irq_flag), .sample_en(sample_en),
  .dac_code(dac_code), .result(result), .done_evt(done_evt), .pcnt(pcnt)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go_wr = 1'b0, irq_clr = 1'b0, clk_sel = 1'b0, rc_tick = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [9:0] vin = 10'd0;
  logic       comp_hi;
  logic [9:0] dac_code, result;
  logic       sample_en, go_done, irq_flag;
  int         total = 0, fails = 0;

  always #5 clk = ~clk;

  // ideal comparator on the DAC trial code
  assign comp_hi = (vin >= dac_code);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .irq_clr(irq_clr),
    .clk_sel(clk_sel), .div_sel(div_sel), .rc_tick(rc_tick),
    .comp_hi(comp_hi), .dac_code(dac_code), .sample_en(sample_en),
    .result(result), .go_done(go_done), .irq_flag(irq_flag)
  );

  // {div_sel, input level}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 10'd0},   {2'd1, 10'd1023}, {2'd2, 10'd512}, {2'd3, 10'd511},
    {2'd0, 10'd341}, {2'd1, 10'd682},  {2'd2, 10'd1},   {2'd0, 10'd1022}
  };

  function automatic int per_len(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // leaves the bench at the falling edge just after the accepting edge
  task automatic start_conv(input logic [9:0] v, input logic [1:0] d, input logic rc);
    vin = v; div_sel = d; clk_sel = rc;
    @(negedge clk); go_wr = 1'b1;
    @(negedge clk); go_wr = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (go_done && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    #1_900_000;
    fails++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, m;
    logic [9:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(go_done == 0 && irq_flag == 0, "R1 flags", {go_done, irq_flag}, 0);
    chk(result == 0 && dac_code == 0, "R1 regs", result, 0);
    chk(sample_en == 1, "R1 sample_en", sample_en, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table walk
    for (int k = 0; k < 8; k++) begin
      prev = result;
      start_conv(VEC[k][9:0], VEC[k][11:10], 1'b0);
      chk(go_done == 1 && sample_en == 0, "R2 start", {go_done, sample_en}, 2);
      chk(dac_code == 0, "R2 setup code", dac_code, 0);
      chk(result == prev, "R6 hold", result, prev);
      wait_done(n);
      chk(n == 12 * per_len(VEC[k][11:10]), "R3 latency", n, 12 * per_len(VEC[k][11:10]));
      chk(result == VEC[k][9:0], "R5 result", result, VEC[k][9:0]);
      chk(irq_flag == 1 && sample_en == 1, "R7 done", {irq_flag, sample_en}, 3);
      clear_irq();
      chk(irq_flag == 0, "R9 clear", irq_flag, 0);
    end

    // R6: result unchanged one edge before completion
    prev = result;
    start_conv(10'd777, 2'd0, 1'b0);
    repeat (23) @(negedge clk);
    chk(go_done == 1 && result == prev, "R6 before end", result, prev);
    @(negedge clk);
    chk(go_done == 0 && result == 10'd777, "R6 at end", result, 777);
    clear_irq();

    // R10: divider change after acceptance
    start_conv(10'd100, 2'd0, 1'b0);
    div_sel = 2'd2; clk_sel = 1'b1;
    wait_done(n);
    chk(n == 24, "R10 captured div", n, 24);
    chk(result == 10'd100, "R10 result", result, 100);
    clear_irq();

    // R8: restart attempt mid-frame
    start_conv(10'd600, 2'd0, 1'b0);
    repeat (5) @(negedge clk);
    go_wr = 1'b1; @(negedge clk); go_wr = 1'b0;
    wait_done(m);
    chk(6 + m == 24, "R8 ignored go", 6 + m, 24);
    chk(result == 10'd600, "R8 result", result, 600);

    // R9: clear on the completion edge, flag already set
    start_conv(10'd55, 2'd0, 1'b0);
    repeat (23) @(negedge clk);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(go_done == 0 && irq_flag == 1, "R9 set wins", irq_flag, 1);
    clear_irq();
    chk(irq_flag == 0, "R9 clear after", irq_flag, 0);

    // R4: RC timebase
    start_conv(10'd300, 2'd0, 1'b1);
    rc_tick = 1'b1;
    repeat (4) @(negedge clk);
    rc_tick = 1'b0;
    chk(go_done == 1 && dac_code == 0, "R4 holdoff ignores ticks", dac_code, 0);
    repeat (11) begin
      @(negedge clk); rc_tick = 1'b1;
      @(negedge clk); rc_tick = 1'b0;
    end
    chk(go_done == 1, "R4 busy after 11 ticks", go_done, 1);
    @(negedge clk); rc_tick = 1'b1;
    @(negedge clk); rc_tick = 1'b0;
    chk(go_done == 0, "R4 done on 12th tick", go_done, 0);
    chk(result == 10'd300 && irq_flag == 1, "R4 result", result, 300);

    // R1: reset mid-frame returns to idle
    start_conv(10'd900, 2'd2, 1'b0);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(go_done == 0 && irq_flag == 0 && result == 0, "R1 reset mid-frame", result, 0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule